// File: doc/BRIEF.md
# SPI Interrupt Set/Clear Register Bank

This block is the interrupt-control slice of an SPI controller. It turns conditions reported by the SPI engine into latched status bits. Those conditions are a mode-fault pulse and the fill levels of the transmit and receive FIFOs. Software clears the latched bits by writing ones to them. Enable bits are never written directly. One write-only address sets them, a second write-only address clears them, and a read-only address reflects the resulting mask. A single active-high interrupt line is raised when any enabled status bit is set.

A transmit watermark register holds a threshold. Whenever the transmit FIFO holds fewer entries than that threshold, the low-water source is asserted. This lets an interrupt handler refill the FIFO before it runs dry. The bus is a plain synchronous register port: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `spi_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, the status and mask registers read 0, the watermark register reads 1, and `irq` is 0.
- R2: A one-cycle `fault_pulse` sets status bit 1 on the next clock edge, and the bit stays set until software clears it.
- R3: A write to the status register at offset 0x04 clears exactly the bits written as 1. Bits written as 0 keep their value, so writing back a value just read clears only those bits.
- R4: A write at offset 0x08 sets the mask bits written as 1 and leaves the others unchanged. The mask reads back at offset 0x10.
- R5: A write at offset 0x0C clears the mask bits written as 1 and leaves the others unchanged.
- R6: The level sources are re-evaluated on every clock: bit 4 (receive level nonzero), bit 3 (transmit level equal to FIFO depth) and bit 2 (transmit level below the watermark). If the condition still holds, a cleared bit sets again on the next edge.
- R7: When a source is active in the same cycle as a clearing write to its bit, the bit stays set.
- R8: `irq` equals the OR of (status AND mask) as it stood one clock earlier.
- R9: The watermark register at offset 0x28 is read/write over the level width, and the below-watermark compare uses the newly written threshold from the following cycle on.
- R10: Reads of the write-only offsets 0x08 and 0x0C, and of any unmapped offset, return 0. Writes to the read-only mask offset 0x10 leave the mask unchanged.
- R11: Bits 0, 5 and 6 of the 7-bit status and mask layout, and all bits above bit 6, always read 0. Writing 0x7F to any of the interrupt registers is therefore safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| fault_pulse | input | 1 | One-cycle mode-fault event from the SPI engine |
| tx_level | input | 8 | Current transmit FIFO fill level |
| rx_level | input | 8 | Current receive FIFO fill level |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest situation to reach from the ports is a clearing write that lands in the same cycle as a still-active source. This includes a fault pulse arriving exactly when software writes a one to bit 1. The bench produces this case on purpose, and it also lets random status writes collide with random FIFO levels and fault pulses over several hundred cycles. A second awkward case is a watermark change: the low-water bit must follow the new threshold one cycle later, so the bench rewrites the threshold while the transmit level sits just below or just at it.

// File: rtl/spi_irq_pkg.sv
// Package: shared constants and types of the SPI interrupt bank.
// Assumes a 7-bit interrupt layout with four implemented sources.
package spi_irq_pkg;
    localparam int NSRC        = 7;
    localparam int BIT_FAULT   = 1;
    localparam int BIT_TXLOW   = 2;
    localparam int BIT_TXFULL  = 3;
    localparam int BIT_RXAVAIL = 4;
    localparam logic [NSRC-1:0] SRC_IMPL = 7'b0011110;

    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SET    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_WMARK  = 6'h28;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_eval.sv
// Module: irq_src_eval
// Forms the per-cycle event vector from the engine inputs.
// Assumes levels are valid every cycle and the fault input is a pulse.
module irq_src_eval #(
    parameter int DEPTH = 128,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                  fault_pulse,
    input  logic [LVL_W-1:0]      tx_level,
    input  logic [LVL_W-1:0]      rx_level,
    input  logic [LVL_W-1:0]      thresh,
    output spi_irq_pkg::src_vec_t events
);
    import spi_irq_pkg::*;

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    // Purpose: map each source condition onto its bit position.
    always_comb begin
        events              = '0;
        events[BIT_FAULT]   = fault_pulse;
        events[BIT_TXLOW]   = (tx_level < thresh);
        events[BIT_TXFULL]  = (tx_level == FULL_LVL);
        events[BIT_RXAVAIL] = (rx_level != '0);
    end
endmodule

// File: rtl/irq_w1c_status.sv
// Module: irq_w1c_status
// Status register in which events set bits and write-one clears them.
// Assumes an event wins over a clear in the same cycle; bits not implemented stay 0.
module irq_w1c_status (
    input  logic                  clk,
    input  logic                  rst_n,
    input  spi_irq_pkg::src_vec_t events,
    input  spi_irq_pkg::src_vec_t clr_bits,
    output spi_irq_pkg::src_vec_t stat_q
);
    import spi_irq_pkg::*;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (SRC_IMPL[i]) begin : g_impl
            // Purpose: latch an event, else drop the bit on a one-write.
            always_ff @(posedge clk) begin
                if (!rst_n)           stat_q[i] <= 1'b0;
                else if (events[i])   stat_q[i] <= 1'b1;
                else if (clr_bits[i]) stat_q[i] <= 1'b0;
            end

            assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
                events[i] |=> stat_q[i]);
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_bits[i] && !events[i]) |=> !stat_q[i]);
            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_bits[i] && !events[i]) |=> $stable(stat_q[i]));
        end else begin : g_tie
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_setclr.sv
// Module: irq_mask_setclr
// Enable mask updated only through separate set and clear strobes.
// Assumes set and clear never arrive in the same cycle (distinct addresses).
module irq_mask_setclr (
    input  logic                  clk,
    input  logic                  rst_n,
    input  spi_irq_pkg::src_vec_t set_bits,
    input  spi_irq_pkg::src_vec_t clr_bits,
    output spi_irq_pkg::src_vec_t mask_q
);
    import spi_irq_pkg::*;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (SRC_IMPL[i]) begin : g_impl
            // Purpose: set or clear one enable bit on its strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)           mask_q[i] <= 1'b0;
                else if (set_bits[i]) mask_q[i] <= 1'b1;
                else if (clr_bits[i]) mask_q[i] <= 1'b0;
            end

            assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                set_bits[i] |=> mask_q[i]);
            assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_bits[i] && !set_bits[i]) |=> !mask_q[i]);
        end else begin : g_tie
            assign mask_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/spi_irq_bank.sv
// Module: spi_irq_bank (top)
// Interrupt register bank: W1C status, set/clear mask, watermark, combined irq.
// Assumes a single-cycle write strobe and combinational reads without side effects.
module spi_irq_bank #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [spi_irq_pkg::ADDR_W-1:0] bus_addr,
    input  logic                           bus_wr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic                           fault_pulse,
    input  logic [LVL_W-1:0]               tx_level,
    input  logic [LVL_W-1:0]               rx_level,
    output logic                           irq
);
    import spi_irq_pkg::*;

    localparam logic [LVL_W-1:0] WMARK_RST = LVL_W'(1);

    src_vec_t         events, stat_q, mask_q;
    src_vec_t         stat_clr, mask_set, mask_clr, wr_bits;
    logic [LVL_W-1:0] wmark_q;
    logic             irq_q;

    assign wr_bits = bus_wdata[NSRC-1:0];

    // Purpose: decode the write strobe into per-register bit strobes.
    always_comb begin
        stat_clr = (bus_wr && bus_addr == OFS_STATUS) ? wr_bits : '0;
        mask_set = (bus_wr && bus_addr == OFS_SET)    ? wr_bits : '0;
        mask_clr = (bus_wr && bus_addr == OFS_CLR)    ? wr_bits : '0;
    end

    // Purpose: hold the transmit watermark threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wmark_q <= WMARK_RST;
        else if (bus_wr && bus_addr == OFS_WMARK) wmark_q <= bus_wdata[LVL_W-1:0];
    end

    irq_src_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_src (
        .fault_pulse (fault_pulse),
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .thresh      (wmark_q),
        .events      (events)
    );

    irq_w1c_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .clr_bits (stat_clr),
        .stat_q   (stat_q)
    );

    irq_mask_setclr u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (mask_set),
        .clr_bits (mask_clr),
        .mask_q   (mask_q)
    );

    // Purpose: register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(stat_q & mask_q);
    end
    assign irq = irq_q;

    // Purpose: return the addressed register; write-only and unmapped read 0.
    always_comb begin
        case (bus_addr)
            OFS_STATUS: bus_rdata = DATA_W'(stat_q);
            OFS_MASK:   bus_rdata = DATA_W'(mask_q);
            OFS_WMARK:  bus_rdata = DATA_W'(wmark_q);
            default:    bus_rdata = '0;
        endcase
    end

    assert_irq_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q)) |=> irq);
    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & mask_q)) |=> !irq);
    assert_mask_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK) |=> $stable(mask_q));
    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | mask_q) & ~SRC_IMPL) == '0);
endmodule

// File: tb/tb_spi_irq_bank.sv
module tb_spi_irq_bank;
    import spi_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 128;
    localparam int DW    = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              fault_pulse = 1'b0;
    logic [LVL_W-1:0]  tx_level = LVL_W'(5);
    logic [LVL_W-1:0]  rx_level = '0;
    logic              irq;

    int checks = 0;
    int failures = 0;

    src_vec_t         m_stat, m_mask;
    logic [LVL_W-1:0] m_thr;
    logic             m_irq;

    spi_irq_bank #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_pulse(fault_pulse),
        .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic src_vec_t exp_events(input logic f, input logic [LVL_W-1:0] tx,
                                            input logic [LVL_W-1:0] rx,
                                            input logic [LVL_W-1:0] thr);
        src_vec_t e = '0;
        e[1] = f;
        e[2] = (tx < thr);
        e[3] = (tx == LVL_W'(DEPTH));
        e[4] = (rx != '0);
        return e;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: update the model from inputs driven before the edge
    task automatic tick();
        src_vec_t ev, wb, nstat, nmask;
        logic [LVL_W-1:0] nthr;
        @(posedge clk);
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_thr = LVL_W'(1); m_irq = 1'b0;
        end else begin
            ev = exp_events(fault_pulse, tx_level, rx_level, m_thr) & SRC_IMPL;
            wb = bus_wdata[NSRC-1:0] & SRC_IMPL;
            nstat = m_stat; nmask = m_mask; nthr = m_thr;
            if (bus_wr && bus_addr == OFS_STATUS) nstat = nstat & ~wb;
            nstat = nstat | ev;
            if (bus_wr && bus_addr == OFS_SET) nmask = nmask | wb;
            if (bus_wr && bus_addr == OFS_CLR) nmask = nmask & ~wb;
            if (bus_wr && bus_addr == OFS_WMARK) nthr = bus_wdata[LVL_W-1:0];
            m_irq = |(m_stat & m_mask);
            m_stat = nstat; m_mask = nmask; m_thr = nthr;
        end
        @(negedge clk);
    endtask

    task automatic read_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp);
        bus_wr = 1'b0; bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        read_chk({tag, " status"}, OFS_STATUS, DW'(m_stat));
        read_chk({tag, " mask"},   OFS_MASK,   DW'(m_mask));
        read_chk({tag, " wmark"},  OFS_WMARK,  DW'(m_thr));
        check({tag, " irq"}, DW'(irq), DW'(m_irq));
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_wdata = '0; fault_pulse = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        void'($urandom(32'd1234));
        m_stat = '0; m_mask = '0; m_thr = LVL_W'(1); m_irq = 1'b0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: fault pulse latches and holds
        fault_pulse = 1'b1; tick(); idle();
        check_all("R2 fault latched");
        tick(); tick();
        read_chk("R2 fault held", OFS_STATUS, DW'(m_stat));
        check("R2 bit1 set", DW'(bus_rdata[BIT_FAULT]), 32'd1);

        // R4/R8: enable fault, irq follows one cycle later
        wr(OFS_SET, 32'h2); tick(); idle();
        check_all("R4 set mask");
        tick();
        check("R8 irq raised", DW'(irq), 32'd1);

        // R3: write back the value just read
        rx_level = LVL_W'(2); tick();
        read_chk("R6 rx bit", OFS_STATUS, DW'(m_stat));
        rd = bus_rdata;
        rx_level = '0;
        wr(OFS_STATUS, rd); tick(); idle();
        check_all("R3 w1c readback");
        check("R3 bits cleared", DW'(m_stat & rd[NSRC-1:0]), 32'd0);

        // R6: level source re-sets after clear
        rx_level = LVL_W'(3); tick();
        wr(OFS_STATUS, 32'h10); tick(); idle();
        check_all("R6 rx re-set");
        tx_level = LVL_W'(DEPTH); tick();
        check_all("R6 tx full");

        // R7: fault pulse collides with its clear
        wr(OFS_STATUS, 32'h2); tick(); idle();
        fault_pulse = 1'b1; wr(OFS_STATUS, 32'h2); tick(); idle();
        check_all("R7 event wins");
        check("R7 bit1 kept", DW'(m_stat[BIT_FAULT]), 32'd1);

        // R9: watermark change
        wr(OFS_WMARK, 32'd10); tx_level = LVL_W'(9); tick(); idle();
        wr(OFS_STATUS, 32'h7F); tick(); idle();
        check_all("R9 below threshold");
        tx_level = LVL_W'(10); wr(OFS_STATUS, 32'h7F); tick(); idle();
        tick();
        check_all("R9 at threshold");

        // R5: disable clears
        wr(OFS_SET, 32'h7F); tick();
        wr(OFS_CLR, 32'h12); tick(); idle();
        check_all("R5 clr mask");

        // R10: read-only mask ignores writes, write-only reads zero
        wr(OFS_MASK, 32'h7F); tick(); idle();
        check_all("R10 mask ro");
        read_chk("R10 set reads 0", OFS_SET, '0);
        read_chk("R10 clr reads 0", OFS_CLR, '0);
        read_chk("R10 unmapped", 6'h3C, '0);

        // R11: all-ones write leaves unused bits zero
        wr(OFS_SET, 32'hFFFF_FFFF); tick(); idle();
        read_chk("R11 mask unused", OFS_MASK, DW'(m_mask));
        check("R11 only impl", bus_rdata & ~DW'(SRC_IMPL), 32'd0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int sel;
            fault_pulse = ($urandom_range(0, 3) == 0);
            tx_level = LVL_W'($urandom_range(0, DEPTH));
            if ($urandom_range(0, 4) == 0) tx_level = LVL_W'(DEPTH);
            rx_level = ($urandom_range(0, 2) == 0) ? '0 : LVL_W'($urandom_range(1, DEPTH));
            sel = $urandom_range(0, 6);
            bus_wdata = $urandom();
            case (sel)
                0: wr(OFS_STATUS, bus_wdata);
                1: wr(OFS_SET, bus_wdata);
                2: wr(OFS_CLR, bus_wdata);
                3: wr(OFS_WMARK, DW'($urandom_range(0, DEPTH + 2)));
                4: wr(OFS_MASK, bus_wdata);
                default: bus_wr = 1'b0;
            endcase
            tick(); idle();
            check_all("R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule